// File: doc/BRIEF.md
# Flash Self-Programming Page Controller

This block lets a processor rewrite its own program flash one page at a time. Software first writes a command register, choosing one of four operations: load a data word into a page buffer, erase a page, program a page from the buffer, or release the read-while-write region. Software then pulses a programming strobe while it presents a word pointer and a data word. The strobe must arrive within a short window after the register write, or the command lapses. Erase and program operations are timed by a cycle counter. Neither one starts while an EEPROM write is still pending.

The flash is split into two regions. The low region can be read while a page is being programmed. The high region cannot. When an erase or program targets the low region, a busy flag is set and held for that region, and reads from it return nothing valid. The flag stays set until software issues the release command. A timed erase or program that is under way runs to completion even if reset is asserted during it.

The controller is a four-state machine. IDLE goes to ARMED when the register is written with the enable bit set. ARMED goes back to IDLE on an executed fill or release, on a rejected pointer, or when the window expires. ARMED goes to EEWAIT when an erase or program is accepted. EEWAIT goes to PROG once the EEPROM is idle. PROG goes to IDLE when the duration counter reaches zero, and the result is applied to the array at that point.

Top module: `flash_selfprog_ctrl`

## Requirements
- R1: The command bits are: bit0 enable, bit1 erase, bit2 program, bit3 release. A register write arms a command only when bit0 is 1. With bit0 set and no other bit, the command is fill. When several command bits are set, erase wins over program, and program wins over release.
- R2: A strobe is executed only if it is sampled on one of the 4 rising edges that follow the register-write edge. A strobe sampled later, or with no armed command, is ignored. The armed state ends after the 4th such edge.
- R3: spm_busy is high from the edge after an enabling register write until the command has finished. Register writes made while spm_busy is high are ignored.
- R4: Fill stores wdata into the page-buffer entry selected by pointer bits [7:1].
- R5: A command whose pointer has bit0 set is rejected, with no effect, and the machine returns to IDLE. A page program with nonzero pointer bits [7:1] is rejected in the same way.
- R6: Erase sets all 128 words of the page selected by pointer bits [11:8] to 0xFFFF.
- R7: Program copies the page buffer into the selected page and then resets every buffer entry to 0xFFFF.
- R8: With the EEPROM idle, spm_busy falls on the (PROG_CYCLES+1)th rising edge after the edge that accepted an erase or program strobe.
- R9: While ee_busy is high, an accepted erase or program waits in EEWAIT. Once ee_busy is low, spm_busy falls PROG_CYCLES+1 edges later.
- R10: rww_busy is set when an erase or program of a page below RWW_PAGES starts timing. It is cleared only by an executed release command or by reset. A page at or above RWW_PAGES leaves it unchanged.
- R11: Reads are registered, one edge. If rww_busy is high and the word address is below RWW_PAGES*128, the read returns rd_ok=0 and rd_data=0. Otherwise it returns rd_ok=1 and the stored word.
- R12: A low rst_n clears the state, rww_busy and the buffer (to 0xFFFF) on a clock edge. While PROG is running, reset is held off: the operation completes and its result is applied, and only then does reset take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_we | input | 1 | Command register write |
| csr_wdata | input | 4 | Command bits {release, program, erase, enable} |
| ptr | input | 12 | Pointer: [11:8] page, [7:1] word, [0] must be 0 |
| wdata | input | 16 | Data word for fill |
| spm_strobe | input | 1 | Programming strobe |
| ee_busy | input | 1 | EEPROM write in progress |
| rd_addr | input | 11 | Word address for reads |
| rd_data | output | 16 | Read data |
| rd_ok | output | 1 | Read data valid |
| spm_busy | output | 1 | Command armed or in progress |
| rww_busy | output | 1 | Read-while-write region locked |

## Verification
A fill or release takes effect on the strobe edge itself, so spm_busy is sampled low at the following falling edge. An erase or program lowers spm_busy PROG_CYCLES+1 edges after its strobe, or after ee_busy falls. The bench counts falling edges until spm_busy drops and compares that count with the formula. Reads are checked one full clock after the address is applied. Array contents are checked only after a release command, by sweeping every word of the page against a pattern computed in the bench.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_EEWAIT,
        ST_PROG
    } fsp_state_e;

    typedef enum logic [1:0] {
        OP_FILL,
        OP_ERASE,
        OP_WRITE,
        OP_RELEASE
    } fsp_op_e;

    localparam int CSR_EN    = 0;
    localparam int CSR_ERASE = 1;
    localparam int CSR_WRITE = 2;
    localparam int CSR_REL   = 3;

    // erase wins over program, program wins over release
    function automatic fsp_op_e decode_op(input logic [3:0] bits);
        if (bits[CSR_ERASE])      return OP_ERASE;
        else if (bits[CSR_WRITE]) return OP_WRITE;
        else if (bits[CSR_REL])   return OP_RELEASE;
        else                      return OP_FILL;
    endfunction

endpackage

// File: rtl/fsp_down_cnt.sv
module fsp_down_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] cnt,
    output logic         zero
);
    always_ff @(posedge clk) begin
        if (clr)                  cnt <= '0;
        else if (load)            cnt <= load_val;
        else if (dec && cnt != 0) cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/fsp_page_buf.sv
module fsp_page_buf #(
    parameter int WORD_W     = 16,
    parameter int PAGE_WORDS = 128,
    parameter int IDX_W      = 7
) (
    input  logic                                clk,
    input  logic                                clr,
    input  logic                                we,
    input  logic [IDX_W-1:0]                    idx,
    input  logic [WORD_W-1:0]                   wdata,
    output logic [PAGE_WORDS-1:0][WORD_W-1:0]   page_q
);
    always_ff @(posedge clk) begin
        if (clr)     page_q <= '1;
        else if (we) page_q[idx] <= wdata;
    end
endmodule

// File: rtl/fsp_array.sv
module fsp_array #(
    parameter int WORD_W     = 16,
    parameter int IDX_W      = 7,
    parameter int PG_W       = 4,
    parameter int RWW_PAGES  = 15,
    localparam int PAGE_WORDS = 1 << IDX_W,
    localparam int ADDR_W     = PG_W + IDX_W,
    localparam int DEPTH      = 1 << ADDR_W,
    localparam int RWW_WORDS  = RWW_PAGES * PAGE_WORDS
) (
    input  logic                              clk,
    input  logic                              commit,
    input  logic                              commit_erase,
    input  logic [PG_W-1:0]                   commit_page,
    input  logic [PAGE_WORDS-1:0][WORD_W-1:0] page_in,
    input  logic                              rww_lock,
    input  logic [ADDR_W-1:0]                 rd_addr,
    output logic [WORD_W-1:0]                 rd_data,
    output logic                              rd_ok
);
    logic [WORD_W-1:0] mem [DEPTH];
    logic              blocked;

    always_ff @(posedge clk) begin
        if (commit) begin
            for (int w = 0; w < PAGE_WORDS; w++) begin
                mem[{commit_page, IDX_W'(w)}] <= commit_erase ? '1 : page_in[w];
            end
        end
    end

    assign blocked = rww_lock && (int'(rd_addr) < RWW_WORDS);

    always_ff @(posedge clk) begin
        rd_data <= blocked ? '0 : mem[rd_addr];
        rd_ok   <= !blocked;
    end
endmodule

// File: rtl/flash_selfprog_ctrl.sv
module flash_selfprog_ctrl
    import fsp_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int WORD_BITS   = 7,
    parameter int PAGE_BITS   = 4,
    parameter int RWW_PAGES   = 15,
    parameter int PROG_CYCLES = 40000,
    parameter int ARM_WINDOW  = 4,
    localparam int PAGE_WORDS = 1 << WORD_BITS,
    localparam int PTR_W      = PAGE_BITS + WORD_BITS + 1,
    localparam int ADDR_W     = PAGE_BITS + WORD_BITS,
    localparam int PCNT_W     = $clog2(PROG_CYCLES + 1),
    localparam int WCNT_W     = $clog2(ARM_WINDOW + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_we,
    input  logic [3:0]        csr_wdata,
    input  logic [PTR_W-1:0]  ptr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              spm_strobe,
    input  logic              ee_busy,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_ok,
    output logic              spm_busy,
    output logic              rww_busy
);
    fsp_state_e               state_q, state_d;
    fsp_op_e                  op_q;
    logic [PAGE_BITS-1:0]     page_q;
    logic                     prog_active, soft_rst;
    logic                     arm_load, ptr_ok, accept;
    logic                     buf_we, buf_clr, rel_fire, prog_start, commit;
    logic [WCNT_W-1:0]        win_cnt;
    logic                     win_zero;
    logic [PCNT_W-1:0]        prog_cnt;
    logic                     prog_zero;
    logic [PAGE_WORDS-1:0][WORD_W-1:0] buf_page;

    // reset is held off while a timed operation runs
    assign prog_active = (state_q == ST_PROG);
    assign soft_rst    = !rst_n && !prog_active;

    assign arm_load = (state_q == ST_IDLE) && csr_we && csr_wdata[CSR_EN];
    assign accept   = (state_q == ST_ARMED) && spm_strobe;
    assign ptr_ok   = !ptr[0] && !(op_q == OP_WRITE && ptr[WORD_BITS:1] != '0);

    // state register
    always_ff @(posedge clk) begin
        if (soft_rst) state_q <= ST_IDLE;
        else          state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (arm_load) state_d = ST_ARMED;
            ST_ARMED: begin
                if (spm_strobe) begin
                    if (ptr_ok && (op_q == OP_ERASE || op_q == OP_WRITE))
                        state_d = ST_EEWAIT;
                    else
                        state_d = ST_IDLE;
                end else if (win_zero) begin
                    state_d = ST_IDLE;
                end
            end
            ST_EEWAIT: if (!ee_busy)  state_d = ST_PROG;
            ST_PROG:   if (prog_zero) state_d = ST_IDLE;
        endcase
    end

    // outputs and strobes
    always_comb begin
        spm_busy   = (state_q != ST_IDLE);
        buf_we     = accept && ptr_ok && (op_q == OP_FILL);
        rel_fire   = accept && ptr_ok && (op_q == OP_RELEASE);
        prog_start = (state_q == ST_EEWAIT) && !ee_busy;
        commit     = prog_active && prog_zero;
        buf_clr    = soft_rst || (commit && op_q == OP_WRITE);
    end

    always_ff @(posedge clk) begin
        if (soft_rst) begin
            op_q   <= OP_FILL;
            page_q <= '0;
        end else begin
            if (arm_load) op_q   <= decode_op(csr_wdata);
            if (accept)   page_q <= ptr[PTR_W-1:WORD_BITS+1];
        end
    end

    always_ff @(posedge clk) begin
        if (soft_rst)
            rww_busy <= 1'b0;
        else if (prog_start && (int'(page_q) < RWW_PAGES))
            rww_busy <= 1'b1;
        else if (rel_fire)
            rww_busy <= 1'b0;
    end

    fsp_down_cnt #(.W(WCNT_W)) u_win (
        .clk      (clk),
        .clr      (soft_rst),
        .load     (arm_load),
        .load_val (WCNT_W'(ARM_WINDOW - 1)),
        .dec      (state_q == ST_ARMED),
        .cnt      (win_cnt),
        .zero     (win_zero)
    );

    fsp_down_cnt #(.W(PCNT_W)) u_dur (
        .clk      (clk),
        .clr      (soft_rst),
        .load     (prog_start),
        .load_val (PCNT_W'(PROG_CYCLES - 1)),
        .dec      (prog_active),
        .cnt      (prog_cnt),
        .zero     (prog_zero)
    );

    fsp_page_buf #(.WORD_W(WORD_W), .PAGE_WORDS(PAGE_WORDS), .IDX_W(WORD_BITS)) u_buf (
        .clk    (clk),
        .clr    (buf_clr),
        .we     (buf_we),
        .idx    (ptr[WORD_BITS:1]),
        .wdata  (wdata),
        .page_q (buf_page)
    );

    fsp_array #(.WORD_W(WORD_W), .IDX_W(WORD_BITS), .PG_W(PAGE_BITS), .RWW_PAGES(RWW_PAGES)) u_arr (
        .clk          (clk),
        .commit       (commit),
        .commit_erase (op_q == OP_ERASE),
        .commit_page  (page_q),
        .page_in      (buf_page),
        .rww_lock     (rww_busy),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data),
        .rd_ok        (rd_ok)
    );
endmodule

// File: rtl/fsp_checker.sv
module fsp_checker
    import fsp_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int WORD_W     = 16,
    parameter int RWW_WORDS  = 1920,
    parameter int ARM_WINDOW = 4
) (
    input logic              clk,
    input logic              rst_n,
    input fsp_state_e        state,
    input logic              spm_strobe,
    input logic              ee_busy,
    input logic              rww_busy,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [WORD_W-1:0] rd_data,
    input logic              rd_ok
);
    logic [7:0] arm_run;
    logic       in_rww;

    assign in_rww = int'(rd_addr) < RWW_WORDS;

    always_ff @(posedge clk) begin
        if (!rst_n)                 arm_run <= '0;
        else if (state == ST_ARMED) arm_run <= (arm_run == 8'hFF) ? arm_run : arm_run + 8'd1;
        else                        arm_run <= '0;
    end

    AST_ARM_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        arm_run <= 8'(ARM_WINDOW)); // R2

    AST_EE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EEWAIT && ee_busy) |=> (state == ST_EEWAIT)); // R9

    AST_PROG_AFTER_EE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_PROG) |-> !$past(ee_busy)); // R9

    AST_RWW_CLEAR_BY_REL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(rww_busy)) |-> $past(state == ST_ARMED && spm_strobe)); // R10

    AST_RD_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (rww_busy && in_rww) |=> (!rd_ok && rd_data == '0)); // R11

    AST_RD_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        !(rww_busy && in_rww) |=> rd_ok); // R11
endmodule

bind flash_selfprog_ctrl fsp_checker #(
    .ADDR_W     (ADDR_W),
    .WORD_W     (WORD_W),
    .RWW_WORDS  (RWW_PAGES * PAGE_WORDS),
    .ARM_WINDOW (ARM_WINDOW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state_q),
    .spm_strobe (spm_strobe),
    .ee_busy    (ee_busy),
    .rww_busy   (rww_busy),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .rd_ok      (rd_ok)
);

// File: tb/flash_selfprog_ctrl_tb.sv
module flash_selfprog_ctrl_tb;
    localparam int P     = 20;
    localparam int WB    = 7;
    localparam int PB    = 4;
    localparam int PTR_W = PB + WB + 1;
    localparam int AW    = PB + WB;
    localparam logic [3:0] C_FILL  = 4'b0001;
    localparam logic [3:0] C_ERASE = 4'b0011;
    localparam logic [3:0] C_WRITE = 4'b0101;
    localparam logic [3:0] C_REL   = 4'b1001;

    logic             clk = 0;
    logic             rst_n;
    logic             csr_we;
    logic [3:0]       csr_wdata;
    logic [PTR_W-1:0] ptr;
    logic [15:0]      wdata;
    logic             spm_strobe;
    logic             ee_busy;
    logic [AW-1:0]    rd_addr;
    logic [15:0]      rd_data;
    logic             rd_ok;
    logic             spm_busy;
    logic             rww_busy;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    flash_selfprog_ctrl #(.PROG_CYCLES(P)) u_dut (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata),
        .ptr(ptr), .wdata(wdata), .spm_strobe(spm_strobe), .ee_busy(ee_busy),
        .rd_addr(rd_addr), .rd_data(rd_data), .rd_ok(rd_ok),
        .spm_busy(spm_busy), .rww_busy(rww_busy)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] pat(input int pg, input int i);
        return 16'((pg * 4951) ^ (i * 257) ^ 23040);
    endfunction

    task automatic issue(input logic [3:0] cmd, input int page, input int word,
                         input logic b0, input logic [15:0] d, input int gap);
        @(negedge clk);
        csr_we = 1; csr_wdata = cmd;
        @(negedge clk);
        csr_we = 0;
        repeat (gap) @(negedge clk);
        spm_strobe = 1;
        ptr   = PTR_W'((page << (WB + 1)) | (word << 1) | int'(b0));
        wdata = d;
        @(negedge clk);
        spm_strobe = 0;
    endtask

    task automatic wait_done(output int k);
        k = 0;
        while (spm_busy && k < 2000) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic rd(input int addr, output logic [15:0] d, output logic ok);
        @(negedge clk);
        rd_addr = AW'(addr);
        @(negedge clk);
        d = rd_data; ok = rd_ok;
    endtask

    task automatic fill_page(input int pg);
        for (int i = 0; i < 128; i++) issue(C_FILL, 0, i, 1'b0, pat(pg, i), 0);
    endtask

    task automatic prog_page(input logic [3:0] cmd, input int pg);
        int k;
        issue(cmd, pg, 0, 1'b0, 16'h0, 0);
        wait_done(k);
        issue(C_REL, 0, 0, 1'b0, 16'h0, 0);
    endtask

    // mode 1: pattern of pg, mode 0: all ones; one check per page
    task automatic check_page(input int pg, input int mode, input string tag);
        int bad = 0;
        logic [15:0] d;
        logic ok;
        for (int i = 0; i < 128; i++) begin
            rd(pg * 128 + i, d, ok);
            if (!ok || d != ((mode == 1) ? pat(pg, i) : 16'hFFFF)) bad++;
        end
        chk(tag, bad, 0);
    endtask

    initial begin
        #(8 * 150000);
        checks++; errors++;
        $display("FAIL watchdog act=1 exp=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int k;
        logic [15:0] d;
        logic ok;
        rst_n = 0; csr_we = 0; csr_wdata = 0; ptr = 0; wdata = 0;
        spm_strobe = 0; ee_busy = 0; rd_addr = 0;
        repeat (3) @(negedge clk);
        chk("R12 reset spm_busy", int'(spm_busy), 0);
        chk("R12 reset rww_busy", int'(rww_busy), 0);
        rst_n = 1;

        // erase RWW page 0, measure duration
        issue(C_ERASE, 0, 0, 1'b0, 16'h0, 0);
        wait_done(k);
        chk("R8 erase duration", k, P + 1);
        chk("R10 rww_busy after RWW erase", int'(rww_busy), 1);
        rd(5, d, ok);
        chk("R11 blocked ok", int'(ok), 0);
        chk("R11 blocked data", int'(d), 0);
        rd(15 * 128, d, ok);
        chk("R11 NRWW readable", int'(ok), 1);
        issue(C_REL, 0, 0, 1'b0, 16'h0, 0);
        chk("R10 release clears", int'(rww_busy), 0);
        chk("R3 release done", int'(spm_busy), 0);
        check_page(0, 0, "R6 erased page all ones");

        // fill + program, then program with cleared buffer
        fill_page(2);
        prog_page(C_WRITE, 2);
        check_page(2, 1, "R7 R4 programmed pattern");
        prog_page(C_WRITE, 3);
        check_page(3, 0, "R7 buffer cleared after program");

        // pointer rejection
        issue(C_FILL, 0, 5, 1'b0, 16'h1234, 0);
        issue(C_FILL, 0, 6, 1'b1, 16'hAAAA, 0);
        issue(C_WRITE, 4, 5, 1'b0, 16'h0, 0);
        chk("R5 program nonzero word rejected", int'(spm_busy), 0);
        issue(C_ERASE, 2, 0, 1'b1, 16'h0, 0);
        chk("R5 erase bit0 rejected", int'(spm_busy), 0);
        chk("R5 no rww lock", int'(rww_busy), 0);
        check_page(2, 1, "R5 page untouched");
        prog_page(C_WRITE, 4);
        rd(4 * 128 + 5, d, ok);
        chk("R4 word select", int'(d), 16'h1234);
        rd(4 * 128 + 6, d, ok);
        chk("R5 fill bit0 rejected", int'(d), 16'hFFFF);

        // arm window
        issue(C_FILL, 0, 0, 1'b0, 16'hA5A5, 3);
        issue(C_FILL, 0, 1, 1'b0, 16'h5A5A, 4);
        chk("R2 window expired idle", int'(spm_busy), 0);
        issue(4'b0010, 6, 0, 1'b0, 16'h0, 0);
        chk("R1 no enable ignored", int'(spm_busy), 0);
        prog_page(C_WRITE, 5);
        rd(5 * 128 + 0, d, ok);
        chk("R2 strobe on 4th edge", int'(d), 16'hA5A5);
        rd(5 * 128 + 1, d, ok);
        chk("R2 strobe on 5th edge ignored", int'(d), 16'hFFFF);

        // EEPROM wait
        ee_busy = 1;
        issue(C_ERASE, 6, 0, 1'b0, 16'h0, 0);
        repeat (10) @(negedge clk);
        chk("R9 waits busy", int'(spm_busy), 1);
        chk("R9 not started", int'(rww_busy), 0);
        ee_busy = 0;
        wait_done(k);
        chk("R9 duration after ee idle", k, P + 1);
        chk("R10 rww set", int'(rww_busy), 1);
        issue(C_REL, 0, 0, 1'b0, 16'h0, 0);

        // NRWW erase leaves rww_busy alone
        issue(C_ERASE, 15, 0, 1'b0, 16'h0, 0);
        repeat (5) @(negedge clk);
        chk("R10 NRWW no lock", int'(rww_busy), 0);
        rd(2 * 128 + 7, d, ok);
        chk("R11 RWW read during NRWW erase", int'(d), int'(pat(2, 7)));
        wait_done(k);
        chk("R10 NRWW no lock after", int'(rww_busy), 0);

        // priority: erase wins over program
        issue(C_FILL, 0, 0, 1'b0, 16'h1111, 0);
        prog_page(C_WRITE, 9);
        rd(9 * 128, d, ok);
        chk("R7 page 9 programmed", int'(d), 16'h1111);
        issue(4'b0111, 9, 3, 1'b0, 16'h0, 0);
        wait_done(k);
        chk("R1 combined duration", k, P + 1);
        issue(C_REL, 0, 0, 1'b0, 16'h0, 0);
        rd(9 * 128, d, ok);
        chk("R1 erase has priority", int'(d), 16'hFFFF);

        // register write while armed ignored
        @(negedge clk); csr_we = 1; csr_wdata = C_FILL;
        @(negedge clk); csr_wdata = C_ERASE;
        @(negedge clk); csr_we = 0;
        spm_strobe = 1; ptr = PTR_W'((10 << (WB + 1)) | (2 << 1)); wdata = 16'h4242;
        @(negedge clk); spm_strobe = 0;
        chk("R3 fill kept", int'(spm_busy), 0);
        chk("R3 no erase", int'(rww_busy), 0);
        prog_page(C_WRITE, 10);
        rd(10 * 128 + 2, d, ok);
        chk("R3 fill data", int'(d), 16'h4242);

        // reset during program
        issue(C_FILL, 0, 3, 1'b0, 16'hBEEF, 0);
        issue(C_WRITE, 7, 0, 1'b0, 16'h0, 0);
        repeat (5) @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        chk("R12 program continues in reset", int'(spm_busy), 1);
        repeat (P + 5) @(negedge clk);
        chk("R12 idle after", int'(spm_busy), 0);
        chk("R12 rww cleared", int'(rww_busy), 0);
        rst_n = 1;
        rd(7 * 128 + 3, d, ok);
        chk("R12 program completed", int'(d), 16'hBEEF);
        rd(7 * 128 + 0, d, ok);
        chk("R12 other word", int'(d), 16'hFFFF);

        // reset clears buffer
        issue(C_FILL, 0, 8, 1'b0, 16'h7777, 0);
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        prog_page(C_WRITE, 11);
        rd(11 * 128 + 8, d, ok);
        chk("R12 buffer reset", int'(d), 16'hFFFF);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule